// File: doc/BRIEF.md
# DMA Request Priority Arbiter

This block chooses which of several requesters is served next. The requesters are two external DMA request lines, a set of serial-channel service requests and one USB service request. Each clock cycle in which no grant is outstanding, it picks one pending requester and registers a one-hot grant. That grant holds until the served requester acknowledges it. The arbiter then goes idle for one cycle and picks again.

Each external DMA line has its own capture mode. Level capture treats the line as pending while it is high. Edge capture latches a rising edge into a sticky flag, which clears only when the grant for that line is acknowledged. A 2-bit priority field places the DMA pair in one of three positions: above every serial channel and USB, between the serial channels and USB, or below all of them. The unused code is handled like the lowest slot and raises an error flag. An interrupt enable lets DMA line 0 also signal the controller. Every raw request passes through a two-stage synchronizer before it is used.

Top module: `dma_prio_arb`

## Requirements
- R1: Every request input passes two synchronizer flops. A level request applied while the arbiter is idle appears on its grant bit after the third rising clock edge. A rising edge in edge mode appears after the fourth rising clock edge.
- R2: In edge mode (mode bit 0), a rising edge on a DMA line sets a pending flag. The flag stays set after the line falls, and it clears when that line's grant is acknowledged. A line held high after it is served is not granted again.
- R3: In level mode (mode bit 1), a DMA line is pending only while it is high. A pulse that ends before the line can be granted leaves no request behind, and a line held high is granted again after each acknowledge.
- R4: With priority field 00, the order is DMA 0, DMA 1, serial 0 through serial N-1, then USB.
- R5: With priority field 01, the order is serial 0 through serial N-1, DMA 0, DMA 1, then USB.
- R6: With priority field 10, the order is serial 0 through serial N-1, USB, DMA 0, then DMA 1.
- R7: Priority field 11 orders requests as 10 does. The error output is 1 from the edge after 11 is applied until the edge after another value is applied.
- R8: Grant and acknowledge bits use this map: bit 0 is DMA 0, bit 1 is DMA 1, bit 2+i is serial channel i, and bit N+2 is USB. At most one grant bit is high.
- R9: A grant stays unchanged until the acknowledge bit at its position is high at a clock edge. The grant is all zero after that edge, and a new grant is chosen at the following edge.
- R10: The interrupt output is 1 one edge after the enable is 1 and DMA 0 is pending. It is 0 whenever the enable is 0, and DMA 1 never drives it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_lvl | input | 2 | Capture mode per DMA line (1 = level, 0 = edge) |
| cfg_prio | input | 2 | Priority slot of the DMA pair |
| cfg_irq_en | input | 1 | Lets DMA 0 raise the interrupt |
| dma_req_i | input | 2 | Raw external DMA requests |
| ser_req_i | input | NSER | Raw serial-channel requests |
| usb_req_i | input | 1 | Raw USB request |
| ack_i | input | NSER+3 | Per-requester acknowledge, using the grant bit map |
| grant_o | output | NSER+3 | One-hot registered grant |
| irq_o | output | 1 | Interrupt from DMA 0 |
| prio_err_o | output | 1 | Reserved priority code in use |

## Verification
The ordering logic is swept over all 128 combinations of the seven level requests under each of the four priority codes. The expected winner is computed from a position list for each code. This sweep separates the three DMA slots and shows that code 11 orders like code 10. It also checks the order inside each group and confirms that a grant holds and then clears on acknowledge.

Directed patterns cover the rest. Exact arrival cycles in each capture mode show the synchronizer depth and the extra edge-detect stage. A short pulse arriving under a higher-priority grant is kept in edge mode and lost in level mode. A line held high is served once in edge mode and again in level mode. Interrupt and error flag cases make up the remaining patterns.

// File: rtl/dma_prio_arb.sv
`timescale 1ns/1ps
module dma_prio_arb #(
  parameter int NSER = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      cfg_lvl,
  input  logic [1:0]      cfg_prio,
  input  logic            cfg_irq_en,
  input  logic [1:0]      dma_req_i,
  input  logic [NSER-1:0] ser_req_i,
  input  logic            usb_req_i,
  input  logic [NSER+2:0] ack_i,
  output logic [NSER+2:0] grant_o,
  output logic            irq_o,
  output logic            prio_err_o
);
  localparam int NREQ = NSER + 3;
  localparam int USB  = NSER + 2;

  logic [NREQ-1:0] s1, s2, eff, win;
  logic [1:0]      dprev, pend, rise, clr, dv, dpick;
  logic [NSER-1:0] sv, spick;
  logic            busy, done;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
      dprev <= '0;
    end else begin
      s1 <= {usb_req_i, ser_req_i, dma_req_i};
      s2 <= s1;
      dprev <= s2[1:0];
    end

  assign rise = s2[1:0] & ~dprev;
  assign clr  = grant_o[1:0] & ack_i[1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pend <= '0;
    else        pend <= ~cfg_lvl & ((pend & ~clr) | rise);

  assign dv  = (cfg_lvl & s2[1:0]) | (~cfg_lvl & pend);
  assign sv  = s2[NREQ-2:2];
  assign eff = {s2[USB], sv, dv};

  assign dpick = dv & (~dv + 2'd1);
  assign spick = sv & (~sv + {{(NSER-1){1'b0}}, 1'b1});

  always_comb begin
    win = '0;
    case (cfg_prio)
      2'b00: begin
        if (|dv)          win[1:0]      = dpick;
        else if (|sv)     win[NREQ-2:2] = spick;
        else              win[USB]      = s2[USB];
      end
      2'b01: begin
        if (|sv)          win[NREQ-2:2] = spick;
        else if (|dv)     win[1:0]      = dpick;
        else              win[USB]      = s2[USB];
      end
      default: begin
        if (|sv)          win[NREQ-2:2] = spick;
        else if (s2[USB]) win[USB]      = 1'b1;
        else              win[1:0]      = dpick;
      end
    endcase
  end

  assign busy = |grant_o;
  assign done = |(grant_o & ack_i);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      grant_o    <= '0;
      irq_o      <= 1'b0;
      prio_err_o <= 1'b0;
    end else begin
      if (done)       grant_o <= '0;
      else if (!busy) grant_o <= win;
      irq_o      <= cfg_irq_en & eff[0];
      prio_err_o <= &cfg_prio;
    end
endmodule

module dma_prio_arb_chk #(
  parameter int NSER = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      cfg_prio,
  input logic            cfg_irq_en,
  input logic [NSER+2:0] ack_i,
  input logic [NSER+2:0] grant_o,
  input logic            irq_o,
  input logic            prio_err_o
);
  // R8
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));
  // R9
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|grant_o) && !(|(grant_o & ack_i))) |=> $stable(grant_o));
  // R9
  grant_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(grant_o & ack_i)) |=> (grant_o == '0));
  // R7
  prio_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_prio == 2'b11) |=> prio_err_o);
  // R7
  prio_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_prio != 2'b11) |=> !prio_err_o);
  // R10
  irq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_irq_en |=> !irq_o);
endmodule

bind dma_prio_arb dma_prio_arb_chk #(.NSER(NSER)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_prio(cfg_prio), .cfg_irq_en(cfg_irq_en),
  .ack_i(ack_i), .grant_o(grant_o), .irq_o(irq_o), .prio_err_o(prio_err_o)
);

// File: tb/dma_prio_arb_tb.sv
`timescale 1ns/1ps
module dma_prio_arb_tb;
  localparam int NSER = 4;
  localparam int NREQ = NSER + 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [1:0]      cfg_lvl = 2'b11;
  logic [1:0]      cfg_prio = 2'b00;
  logic            cfg_irq_en = 1'b0;
  logic [1:0]      dma_req_i = '0;
  logic [NSER-1:0] ser_req_i = '0;
  logic            usb_req_i = 1'b0;
  logic [NREQ-1:0] ack_i = '0;
  logic [NREQ-1:0] grant_o;
  logic            irq_o, prio_err_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  dma_prio_arb #(.NSER(NSER)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_lvl(cfg_lvl), .cfg_prio(cfg_prio),
    .cfg_irq_en(cfg_irq_en), .dma_req_i(dma_req_i), .ser_req_i(ser_req_i),
    .usb_req_i(usb_req_i), .ack_i(ack_i), .grant_o(grant_o), .irq_o(irq_o),
    .prio_err_o(prio_err_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clear_all();
    dma_req_i = '0; ser_req_i = '0; usb_req_i = 1'b0;
    ack_i = '1;
    tick(5);
    ack_i = '0;
    tick(1);
  endtask

  function automatic logic [NREQ-1:0] expect_win(input int prio, input logic [NREQ-1:0] r);
    for (int p = 0; p < NREQ; p++) begin
      int idx;
      if (prio == 0)      idx = p;
      else if (prio == 1) idx = (p < NSER) ? p + 2 : (p < NSER + 2) ? p - NSER : NSER + 2;
      else                idx = (p < NSER + 1) ? p + 2 : p - NSER - 1;
      if (r[idx]) return NREQ'(1) << idx;
    end
    return '0;
  endfunction

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(1);
    check("R9 reset grant", 32'(grant_o), 0);
    check("R10 reset irq", 32'(irq_o), 0);
    check("R7 reset err", 32'(prio_err_o), 0);
    rst_n = 1'b1;
    tick(2);

    for (int pr = 0; pr < 4; pr++) begin
      for (int pat = 0; pat < (1 << NREQ); pat++) begin
        logic [NREQ-1:0] r, e;
        r = NREQ'(pat);
        e = expect_win(pr, r);
        cfg_prio = 2'(pr);
        clear_all();
        dma_req_i = r[1:0]; ser_req_i = r[NREQ-2:2]; usb_req_i = r[NREQ-1];
        tick(5);
        check(pr == 0 ? "R4 R8 order" : pr == 1 ? "R5 R8 order" :
              pr == 2 ? "R6 R8 order" : "R7 R8 order", 32'(grant_o), 32'(e));
        tick(3);
        check("R9 hold", 32'(grant_o), 32'(e));
        ack_i = e;
        tick(1);
        check("R9 drop", 32'(grant_o), 0);
        ack_i = '0;
      end
    end

    cfg_prio = 2'b11; tick(2);
    check("R7 err set", 32'(prio_err_o), 1);
    cfg_prio = 2'b00; tick(2);
    check("R7 err clear", 32'(prio_err_o), 0);

    // R1 exact latency, level then edge
    clear_all();
    cfg_lvl = 2'b11; dma_req_i = 2'b01;
    tick(2); check("R1 level early", 32'(grant_o), 0);
    tick(1); check("R1 level arrive", 32'(grant_o), 1);
    clear_all();
    cfg_lvl = 2'b10; tick(2); dma_req_i = 2'b01;
    tick(3); check("R1 edge early", 32'(grant_o), 0);
    tick(1); check("R1 edge arrive", 32'(grant_o), 1);

    // R2 / R3 held high line served once vs repeatedly
    ack_i = 7'b0000001; tick(1); ack_i = '0;
    tick(4); check("R2 held edge not regranted", 32'(grant_o), 0);
    clear_all();
    cfg_lvl = 2'b11; dma_req_i = 2'b01; tick(5);
    ack_i = 7'b0000001; tick(1); ack_i = '0;
    tick(4); check("R3 held level regranted", 32'(grant_o), 1);

    // R2 / R3 short pulse under a busy serial grant
    for (int m = 0; m < 2; m++) begin
      cfg_prio = 2'b10;
      clear_all();
      cfg_lvl = m == 0 ? 2'b10 : 2'b11;
      tick(2);
      ser_req_i = 4'b0001; tick(5);
      check("R6 serial first", 32'(grant_o), 4);
      dma_req_i = 2'b01; tick(2); dma_req_i = 2'b00; tick(3);
      ser_req_i = '0; tick(3);
      ack_i = 7'b0000100; tick(1); ack_i = '0;
      tick(3);
      if (m == 0) check("R2 pulse kept", 32'(grant_o), 1);
      else        check("R3 pulse lost", 32'(grant_o), 0);
    end

    // R10 interrupt
    cfg_prio = 2'b00;
    clear_all();
    cfg_lvl = 2'b11; cfg_irq_en = 1'b1; dma_req_i = 2'b01; tick(4);
    check("R10 irq on", 32'(irq_o), 1);
    cfg_irq_en = 1'b0; tick(2);
    check("R10 irq disabled", 32'(irq_o), 0);
    cfg_irq_en = 1'b1; dma_req_i = 2'b10; tick(4);
    check("R10 dma1 no irq", 32'(irq_o), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule